// File: doc/BRIEF.md
# Single-Wire Configuration Word Transmitter

This block sits on the host side of a one-wire programming link and turns a configuration word (six bits by default) into a self-timed pulse train on a single output line. No clock travels with the data. Every bit starts with a high setup interval and a short low gap. The rising edge that follows opens the data window. A `1` keeps the line high for the long data time. A `0` keeps it high only for the short time and then holds it low for the recovery time. A receiver that samples at a fixed delay after the data edge therefore reads the bit from the line level alone.

The word enters through a valid/ready handshake. `word_ready` is high exactly when the block is idle, so a word is accepted in the cycle where `word_valid` and `word_ready` are both high. While a transfer runs, `word_ready` stays low. A valid that is withdrawn before `word_ready` returns is never accepted. A valid that is still held when the block goes idle is accepted then. All interval lengths are parameters counted in microsecond ticks. The tick comes from a prescaler that divides the clock by `CLKS_PER_US` and restarts at every acceptance. Each interval therefore lasts an exact number of clock cycles. `busy` covers the whole transfer, and `done` marks its end with a single-cycle pulse.

Top module: `cfg_wire_tx`

## Requirements
- R1: After reset, `line_out`, `busy` and `done` are 0 and `word_ready` is 1.
- R2: A word is accepted on a clock edge where `word_valid` and `word_ready` are both 1. `word_ready` equals the inverse of `busy`. From the next cycle `busy` is 1 and `line_out` is 1.
- R3: Every bit begins with `line_out` high for `T_SETUP*CLKS_PER_US` cycles, followed by `line_out` low for `T_GAP*CLKS_PER_US` cycles.
- R4: For a bit of value 1, the data window holds `line_out` high for `T_ONE*CLKS_PER_US` cycles and then low for `T_TAIL*CLKS_PER_US` cycles.
- R5: For a bit of value 0, the data window holds `line_out` high for `T_ZHI*CLKS_PER_US` cycles and then low for `T_ZLO*CLKS_PER_US` cycles.
- R6: All `WORD_W` bits are sent in every transfer, least significant bit (bit index 0) first, so a transfer contains exactly 4*`WORD_W` line runs.
- R7: The word is captured at acceptance. Changes on `word_data` afterwards, and `word_valid` pulses that are withdrawn while `busy` is 1, have no effect on the waveform and start no further transfer.
- R8: `done` is 1 for exactly one cycle, in the cycle right after the final bit's low interval. In that cycle `busy` is 0. `line_out` is 0 there and stays 0 while idle.
- R9: One tick equals `CLKS_PER_US` clock cycles, with the prescaler restarted at acceptance, so every interval is an exact multiple of `CLKS_PER_US` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_valid | input | 1 | Configuration word offered |
| word_ready | output | 1 | Block idle and able to take a word |
| word_data | input | WORD_W | Configuration word; bit 0 is sent first |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| line_out | output | 1 | Single-wire programming line |

## Verification
The bench measures every high and low run on the line and compares it against run lengths computed from the sent word. A design with a one-tick error in any interval, or with the `0` and `1` patterns swapped, fails there. Sending the all-zero and all-one words, and words with only the first or only the last bit set, catches reversed bit order and dropped or extra bits. In one transfer the bench pulses `word_valid` with a different word mid-flight and scrambles `word_data` after acceptance. A design that re-captured the word would change the waveform, and one that queued the request would start a second train after `done`. The bench also checks that `done` lasts one cycle with the line low, which exposes an early or stretched `done` or a line left high at the end.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_GAP   = 3'd2,
    PH_DHI   = 3'd3,
    PH_DLO   = 3'd4
  } phase_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cfgw_tick.sv
module cfgw_tick #(
  parameter int CLKS_PER_US = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int PW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CLKS_PER_US - 1);

  logic [PW-1:0] pre_q;

  assign tick = en && !clr && (pre_q == PRE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (clr || !en || tick) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  generate
    if (CLKS_PER_US > 1) begin : g_gap
      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R9
    end
  endgenerate

endmodule

// File: rtl/cfgw_word.sv
module cfgw_word #(
  parameter int WORD_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] data,
  input  logic              adv,
  output logic              cur_bit,
  output logic              last_bit
);
  localparam int IW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [IW-1:0] IDX_LAST = IW'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q;
  logic [IW-1:0]     idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (load) begin
      sh_q  <= data;
      idx_q <= '0;
    end else if (adv) begin
      sh_q  <= sh_q >> 1;
      idx_q <= idx_q + 1'b1;
    end
  end

  assign cur_bit  = sh_q[0];
  assign last_bit = (idx_q == IDX_LAST);

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_LAST); // R6
  AST_ADV_NOT_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> !last_bit); // R6

endmodule

// File: rtl/cfgw_phase.sv
module cfgw_phase
  import cfgw_pkg::*;
#(
  parameter int T_SETUP = 50,
  parameter int T_GAP   = 5,
  parameter int T_ONE   = 200,
  parameter int T_ZHI   = 50,
  parameter int T_ZLO   = 150,
  parameter int T_TAIL  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  input  logic cur_bit,
  input  logic last_bit,
  output logic adv,
  output logic busy,
  output logic done,
  output logic line
);
  localparam int DMAX = max2(max2(max2(T_SETUP, T_GAP), max2(T_ONE, T_ZHI)),
                             max2(T_ZLO, T_TAIL));
  localparam int CW = $clog2(DMAX + 1);
  localparam logic [CW-1:0] L_SETUP = CW'(T_SETUP - 1);
  localparam logic [CW-1:0] L_GAP   = CW'(T_GAP - 1);
  localparam logic [CW-1:0] L_ONE   = CW'(T_ONE - 1);
  localparam logic [CW-1:0] L_ZHI   = CW'(T_ZHI - 1);
  localparam logic [CW-1:0] L_ZLO   = CW'(T_ZLO - 1);
  localparam logic [CW-1:0] L_TAIL  = CW'(T_TAIL - 1);

  phase_e        ph_q, ph_n;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;
  logic          ph_end;
  logic          fin;
  logic          line_q, done_q;

  always_comb begin
    unique case (ph_q)
      PH_SETUP: lim = L_SETUP;
      PH_GAP:   lim = L_GAP;
      PH_DHI:   lim = cur_bit ? L_ONE : L_ZHI;
      PH_DLO:   lim = cur_bit ? L_TAIL : L_ZLO;
      default:  lim = '0;
    endcase
  end

  assign ph_end = tick && (ph_q != PH_IDLE) && (cnt_q == lim);
  assign adv    = (ph_q == PH_DLO) && ph_end && !last_bit;
  assign fin    = (ph_q == PH_DLO) && ph_end && last_bit;

  always_comb begin
    ph_n = ph_q;
    unique case (ph_q)
      PH_IDLE:  if (start)  ph_n = PH_SETUP;
      PH_SETUP: if (ph_end) ph_n = PH_GAP;
      PH_GAP:   if (ph_end) ph_n = PH_DHI;
      PH_DHI:   if (ph_end) ph_n = PH_DLO;
      PH_DLO:   if (ph_end) ph_n = last_bit ? PH_IDLE : PH_SETUP;
      default:  ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      line_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_n;
      line_q <= (ph_n == PH_SETUP) || (ph_n == PH_DHI);
      done_q <= fin;
      if (start || ph_end) begin
        cnt_q <= '0;
      end else if (tick) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy = (ph_q != PH_IDLE);
  assign done = done_q;
  assign line = line_q;

  AST_LINE_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_q) |-> ($past(tick) || $past(start))); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R8
  AST_DONE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!line_q && !busy)); // R8
  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (ph_q == PH_IDLE)); // R7

endmodule

// File: rtl/cfg_wire_tx.sv
module cfg_wire_tx #(
  parameter int WORD_W      = 6,
  parameter int CLKS_PER_US = 250,
  parameter int T_SETUP     = 50,
  parameter int T_GAP       = 5,
  parameter int T_ONE       = 200,
  parameter int T_ZHI       = 50,
  parameter int T_ZLO       = 150,
  parameter int T_TAIL      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic [WORD_W-1:0] word_data,
  output logic              busy,
  output logic              done,
  output logic              line_out
);
  logic accept;
  logic tick;
  logic cur_bit, last_bit, adv;
  logic busy_w;

  assign word_ready = !busy_w;
  assign accept     = word_valid && !busy_w;
  assign busy       = busy_w;

  cfgw_tick #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (accept),
    .en   (busy_w),
    .tick (tick)
  );

  cfgw_word #(.WORD_W(WORD_W)) u_word (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .data    (word_data),
    .adv     (adv),
    .cur_bit (cur_bit),
    .last_bit(last_bit)
  );

  cfgw_phase #(
    .T_SETUP(T_SETUP), .T_GAP(T_GAP), .T_ONE(T_ONE),
    .T_ZHI(T_ZHI), .T_ZLO(T_ZLO), .T_TAIL(T_TAIL)
  ) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .tick    (tick),
    .cur_bit (cur_bit),
    .last_bit(last_bit),
    .adv     (adv),
    .busy    (busy_w),
    .done    (done),
    .line    (line_out)
  );

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && line_out && !word_ready)); // R2

endmodule

// File: tb/cfg_wire_tx_tb.sv
module cfg_wire_tx_tb;
  localparam int W   = 6;
  localparam int CPU = 4;
  localparam int TS  = 50;
  localparam int TG  = 10;
  localparam int T1  = 200;
  localparam int TZH = 50;
  localparam int TZL = 150;
  localparam int TT  = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         word_valid = 1'b0;
  logic [W-1:0] word_data = '0;
  logic         word_ready, busy, done, line_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int runs [64];
  int nruns;

  always #2 clk = ~clk;

  cfg_wire_tx #(
    .WORD_W(W), .CLKS_PER_US(CPU), .T_SETUP(TS), .T_GAP(TG),
    .T_ONE(T1), .T_ZHI(TZH), .T_ZLO(TZL), .T_TAIL(TT)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_ready(word_ready),
    .word_data(word_data), .busy(busy), .done(done), .line_out(line_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_run(input logic [W-1:0] w, input int k);
    int b = k / 4;
    case (k % 4)
      0: return TS * CPU;
      1: return TG * CPU;
      2: return (w[b] ? T1 : TZH) * CPU;
      default: return (w[b] ? TT : TZL) * CPU;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic send(input logic [W-1:0] w, input bit inject);
    int len;
    int n;
    int c;
    int bad;
    logic cur;
    logic [W-1:0] got;
    @(negedge clk);
    chk("R2 ready before send", int'(word_ready), 1);
    word_valid = 1'b1;
    word_data  = w;
    @(posedge clk);
    @(negedge clk);
    word_valid = 1'b0;
    word_data  = ~w;
    chk("R2 line high after accept", int'(line_out), 1);
    cur = line_out; len = 0; n = 0; c = 0; bad = 0;
    while (!done && c < 20000) begin
      if (!busy || word_ready) bad++;
      if (line_out == cur) len++;
      else begin
        if (n < 64) runs[n] = len;
        n++; cur = line_out; len = 1;
      end
      if (inject && c == 300) begin word_valid = 1'b1; word_data = 6'h2A; end
      if (inject && c == 304) word_valid = 1'b0;
      c++;
      @(negedge clk);
    end
    if (n < 64) runs[n] = len;
    n++;
    chk("R2 busy held and ready low during transfer", bad, 0);
    chk("R6 run count", n, 4 * W);
    got = '0;
    for (int b = 0; b < W && 4 * b + 3 < n && 4 * b + 3 < 64; b++) begin
      chk($sformatf("R3 setup bit%0d", b), runs[4*b], exp_run(w, 4*b));
      chk($sformatf("R3 gap bit%0d", b), runs[4*b+1], exp_run(w, 4*b+1));
      chk(w[b] ? $sformatf("R4 one high bit%0d", b) : $sformatf("R5 zero high bit%0d", b),
          runs[4*b+2], exp_run(w, 4*b+2));
      chk(w[b] ? $sformatf("R4 one low bit%0d", b) : $sformatf("R5 zero low bit%0d", b),
          runs[4*b+3], exp_run(w, 4*b+3));
      got[b] = (runs[4*b+2] > TZH * CPU);
    end
    chk("R6 decoded word order", int'(got), int'(w));
    chk("R9 setup is multiple of tick", runs[0] % CPU, 0);
    chk("R8 done with busy low", int'(busy), 0);
    chk("R8 done with line low", int'(line_out), 0);
    @(negedge clk);
    chk("R8 done one cycle", int'(done), 0);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      if (line_out || busy || done) bad++;
      @(negedge clk);
    end
    chk(inject ? "R7 no transfer from ignored request" : "R8 idle low after done", bad, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk("R1 line reset", int'(line_out), 0);
    chk("R1 busy reset", int'(busy), 0);
    chk("R1 done reset", int'(done), 0);
    chk("R1 ready reset", int'(word_ready), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 line idle after reset", int'(line_out), 0);
    send(6'h00, 1'b0);
    send(6'h3F, 1'b0);
    send(6'h01, 1'b0);
    send(6'h20, 1'b0);
    send(6'h15, 1'b1);
    for (int i = 0; i < 6; i++) send(W'($urandom), 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule